// File: doc/BRIEF.md
# Outbound Address Translation Window

The block holds one outbound address window and rebases the requests that fall inside it. Software sets up the window through a small register bus. It gives a base address, an inclusive limit, a target address, a transaction kind and an enable bit. A selector register picks which window the other registers reach. Only window 0 exists, so any other selector value hides the window from the register bus.

Each incoming 32-bit request address is compared against the window. A hit is rebased onto the 64-bit target and tagged with the programmed transaction kind. A miss is passed out untranslated with a miss flag.

For the two configuration kinds, the upper half of the target low word is a routing field. It holds bus in bits 31:24, device in bits 23:19 and function in bits 18:16. The lower 16 bits of the result carry the register offset inside the window, with its two low bits forced to zero. The result appears one clock after the request.

Top module: `addr_xlate_region`

## Requirements
- R1: After reset every register reads 0, the window is disabled and rspValid is 0.
- R2: With selector 0, the registers are read back and written at these byte offsets on regAddr:
  - 0x00: selector, all 32 bits.
  - 0x04: kind, bits 2:0.
  - 0x08: enable, bit 31.
  - 0x0C: base low.
  - 0x10: base high.
  - 0x14: limit.
  - 0x18: target low.
  - 0x1C: target high.
  - Any other offset reads 0 and ignores writes.
- R3: With a nonzero selector, offsets 0x04 to 0x1C read 0 and writes to them leave the window unchanged. The selector itself stays readable and writable.
- R4: With the enable bit clear, every request misses.
- R5: A request hits when enable is set, base high is 0, and base low <= reqAddr <= limit. Both ends of the range are inclusive.
- R6: For kinds 0 (memory), 1 (locked memory read) and 2 (I/O), a hit gives rspAddr = {target high, target low + (reqAddr - base low)}, with the low word wrapping at 32 bits.
- R7: For kinds 4 (type-0 configuration) and 5 (type-1 configuration), a hit gives rspAddr = {target high, target low[31:16], off[15:2], 2'b00}, where off = reqAddr - base low.
- R8: On a hit, rspType equals the programmed kind. On a miss, rspType is 0.
- R9: On a miss, rspMiss is 1 and rspAddr is the request address zero-extended to 64 bits.
- R10: rspValid is high exactly one cycle after reqValid, and the result belongs to that request.
- R11: A register write takes effect for requests issued in the following cycle. A request issued in the same cycle as the write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| reqValid | input | 1 | Request present |
| reqAddr | input | 32 | Request address |
| rspValid | output | 1 | Result present |
| rspAddr | output | 64 | Translated or passed-through address |
| rspType | output | 3 | Transaction kind of the result |
| rspMiss | output | 1 | Request fell outside the window |

## Verification
A register write and a translation request can land in the same clock. The write changes the very window the request is compared against. The bench drives both in one cycle in two ways: it clears the enable bit, and it moves the base. It then expects the result computed from the settings before the write, and the next request to see the new settings. A scoreboard queue lines up each expected result with the response that arrives one cycle later, so an early, late or missing response is also reported.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int XW     = 32;
  localparam int REG_AW = 5;
  localparam int KIND_W = 3;
  localparam int CFG_LO = 16;

  localparam logic [REG_AW-1:0] OFS_SEL   = 5'h00;
  localparam logic [REG_AW-1:0] OFS_KIND  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_EN    = 5'h08;
  localparam logic [REG_AW-1:0] OFS_BASEL = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_BASEH = 5'h10;
  localparam logic [REG_AW-1:0] OFS_LIM   = 5'h14;
  localparam logic [REG_AW-1:0] OFS_TGTL  = 5'h18;
  localparam logic [REG_AW-1:0] OFS_TGTH  = 5'h1C;

  localparam logic [KIND_W-1:0] KIND_CFG0 = 3'd4;
  localparam logic [KIND_W-1:0] KIND_CFG1 = 3'd5;

  typedef struct packed {
    logic kind;
    logic enable;
    logic baseLo;
    logic baseHi;
    logic limit;
    logic tgtLo;
    logic tgtHi;
  } strobe_t;

  typedef struct packed {
    logic              enable;
    logic [KIND_W-1:0] kind;
    logic [XW-1:0]     baseLo;
    logic [XW-1:0]     baseHi;
    logic [XW-1:0]     limit;
    logic [XW-1:0]     tgtLo;
    logic [XW-1:0]     tgtHi;
  } region_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [XW-1:0]     regWrData,
  input  region_t           cfg,
  output strobe_t           strb,
  output logic [XW-1:0]     regRdData
);
  logic [XW-1:0] selector;
  logic          winVisible;

  assign winVisible = (selector == '0);

  always_ff @(posedge clk) begin
    if (!rstN)                                 selector <= '0;
    else if (regWrEn && regAddr == OFS_SEL)    selector <= regWrData;
  end

  always_comb begin
    strb = '0;
    if (regWrEn && winVisible) begin
      case (regAddr)
        OFS_KIND:  strb.kind   = 1'b1;
        OFS_EN:    strb.enable = 1'b1;
        OFS_BASEL: strb.baseLo = 1'b1;
        OFS_BASEH: strb.baseHi = 1'b1;
        OFS_LIM:   strb.limit  = 1'b1;
        OFS_TGTL:  strb.tgtLo  = 1'b1;
        OFS_TGTH:  strb.tgtHi  = 1'b1;
        default:   strb = '0;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == OFS_SEL) regRdData = selector;
    else if (winVisible) begin
      case (regAddr)
        OFS_KIND:  regRdData = {{(XW-KIND_W){1'b0}}, cfg.kind};
        OFS_EN:    regRdData = {cfg.enable, {(XW-1){1'b0}}};
        OFS_BASEL: regRdData = cfg.baseLo;
        OFS_BASEH: regRdData = cfg.baseHi;
        OFS_LIM:   regRdData = cfg.limit;
        OFS_TGTL:  regRdData = cfg.tgtLo;
        OFS_TGTH:  regRdData = cfg.tgtHi;
        default:   regRdData = '0;
      endcase
    end
  end

  // R3
  hidden_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && selector != '0 && regAddr != OFS_SEL) |=> $stable(cfg));

  // R2
  sel_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_SEL) |=> (selector == $past(regWrData)));
endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [XW-1:0]     wrData,
  input  logic              reqValid,
  input  logic [XW-1:0]     reqAddr,
  output region_t           cfg,
  output logic              rspValid,
  output logic [2*XW-1:0]   rspAddr,
  output logic [KIND_W-1:0] rspType,
  output logic              rspMiss
);
  logic [XW-1:0]   offs;
  logic            hit;
  logic            isCfg;
  logic [2*XW-1:0] xAddr;

  always_ff @(posedge clk) begin
    if (!rstN) cfg <= '0;
    else begin
      if (strb.kind)   cfg.kind   <= wrData[KIND_W-1:0];
      if (strb.enable) cfg.enable <= wrData[XW-1];
      if (strb.baseLo) cfg.baseLo <= wrData;
      if (strb.baseHi) cfg.baseHi <= wrData;
      if (strb.limit)  cfg.limit  <= wrData;
      if (strb.tgtLo)  cfg.tgtLo  <= wrData;
      if (strb.tgtHi)  cfg.tgtHi  <= wrData;
    end
  end

  assign offs  = reqAddr - cfg.baseLo;
  assign hit   = cfg.enable && (cfg.baseHi == '0) &&
                 (reqAddr >= cfg.baseLo) && (reqAddr <= cfg.limit);
  assign isCfg = (cfg.kind == KIND_CFG0) || (cfg.kind == KIND_CFG1);

  always_comb begin
    if (!hit)       xAddr = {{XW{1'b0}}, reqAddr};
    else if (isCfg) xAddr = {cfg.tgtHi, cfg.tgtLo[XW-1:CFG_LO], offs[CFG_LO-1:2], 2'b00};
    else            xAddr = {cfg.tgtHi, cfg.tgtLo + offs};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspType  <= '0;
      rspMiss  <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspAddr  <= xAddr;
      rspType  <= hit ? cfg.kind : '0;
      rspMiss  <= !hit;
    end
  end

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R9
  miss_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMiss) |-> (rspAddr == {{XW{1'b0}}, $past(reqAddr)}));

  // R4
  disabled_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cfg.enable) |=> rspMiss);

  // R7
  cfg_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspMiss && (rspType == KIND_CFG0 || rspType == KIND_CFG1))
      |-> (rspAddr[1:0] == 2'b00));

  // R8
  miss_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMiss) |-> (rspType == '0));
endmodule

// File: rtl/addr_xlate_region.sv
module addr_xlate_region
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [XW-1:0]     regWrData,
  output logic [XW-1:0]     regRdData,
  input  logic              reqValid,
  input  logic [XW-1:0]     reqAddr,
  output logic              rspValid,
  output logic [2*XW-1:0]   rspAddr,
  output logic [KIND_W-1:0] rspType,
  output logic              rspMiss
);
  strobe_t strb;
  region_t cfg;

  xlate_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .cfg(cfg), .strb(strb), .regRdData(regRdData)
  );

  xlate_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .reqValid(reqValid), .reqAddr(reqAddr), .cfg(cfg),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspType(rspType), .rspMiss(rspMiss)
  );
endmodule

// File: tb/sim_addr_xlate_region.sv
`timescale 1ns/1ps
module sim_addr_xlate_region;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid;
  logic [63:0] rspAddr;
  logic [2:0]  rspType;
  logic        rspMiss;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] a;
    logic [2:0]  t;
    logic        m;
    string       tag;
  } exp_t;
  exp_t q[$];

  // shadow of the programmed window
  logic [31:0] mSel = 0, mBaseLo = 0, mBaseHi = 0, mLim = 0, mTgtLo = 0, mTgtHi = 0;
  logic [2:0]  mKind = 0;
  logic        mEn = 0;

  always #10 clk = ~clk;

  addr_xlate_region u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspAddr(rspAddr),
    .rspType(rspType), .rspMiss(rspMiss)
  );

  function automatic exp_t model(input logic [31:0] a, input string tag);
    exp_t e;
    logic hit;
    logic [31:0] off;
    hit = mEn && (mBaseHi == 0) && (a >= mBaseLo) && (a <= mLim);
    off = a - mBaseLo;
    e.tag = tag;
    if (!hit) begin
      e.a = {32'h0, a}; e.t = 3'd0; e.m = 1'b1;
    end else if (mKind == 3'd4 || mKind == 3'd5) begin
      e.a = {mTgtHi, mTgtLo[31:16], off[15:2], 2'b00}; e.t = mKind; e.m = 1'b0;
    end else begin
      e.a = {mTgtHi, mTgtLo + off}; e.t = mKind; e.m = 1'b0;
    end
    return e;
  endfunction

  function automatic logic [31:0] readModel(input logic [4:0] off);
    if (off == 5'h00) return mSel;
    if (mSel != 0) return 32'h0;
    case (off)
      5'h04: return {29'h0, mKind};
      5'h08: return {mEn, 31'h0};
      5'h0C: return mBaseLo;
      5'h10: return mBaseHi;
      5'h14: return mLim;
      5'h18: return mTgtLo;
      5'h1C: return mTgtHi;
      default: return 32'h0;
    endcase
  endfunction

  task automatic shadowWrite(input logic [4:0] off, input logic [31:0] d);
    if (off == 5'h00) mSel = d;
    else if (mSel == 0) begin
      case (off)
        5'h04: mKind = d[2:0];
        5'h08: mEn = d[31];
        5'h0C: mBaseLo = d;
        5'h10: mBaseHi = d;
        5'h14: mLim = d;
        5'h18: mTgtLo = d;
        5'h1C: mTgtHi = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [4:0] off, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b0;
    regWrEn = 1'b1; regAddr = off; regWrData = d;
    shadowWrite(off, d);
  endtask

  task automatic req(input logic [31:0] a, input string tag);
    @(negedge clk);
    regWrEn = 1'b0;
    reqValid = 1'b1; reqAddr = a;
    q.push_back(model(a, tag));
  endtask

  // write and request in the same cycle: request sees old settings (R11)
  task automatic wrReq(input logic [4:0] off, input logic [31:0] d,
                       input logic [31:0] a, input string tag);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = off; regWrData = d;
    reqValid = 1'b1; reqAddr = a;
    q.push_back(model(a, tag));
    shadowWrite(off, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      regWrEn = 1'b0; reqValid = 1'b0;
    end
  endtask

  task automatic rd(input logic [4:0] off, input string tag);
    logic [31:0] e;
    @(negedge clk);
    regWrEn = 1'b0; reqValid = 1'b0; regAddr = off;
    #1;
    e = readModel(off);
    checks++;
    if (regRdData !== e) begin
      errors++;
      $display("FAIL %s: read offset %h got %h expected %h", tag, off, regRdData, e);
    end
  endtask

  // monitor: scoreboard compare, sampled on the falling edge (R10)
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10: response with no pending request got %h expected none", rspAddr);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rspAddr !== e.a || rspType !== e.t || rspMiss !== e.m) begin
          errors++;
          $display("FAIL %s: got addr=%h type=%0d miss=%0d expected addr=%h type=%0d miss=%0d",
                   e.tag, rspAddr, rspType, rspMiss, e.a, e.t, e.m);
        end
      end
    end
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung got running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    checks++;
    if (rspValid !== 1'b0) begin
      errors++; $display("FAIL R1: rspValid got %b expected 0", rspValid);
    end
    for (int k = 0; k < 8; k++) rd(5'(k * 4), "R1 reset readback");

    // R4 / R9: disabled window passes through
    req(32'h0100_0010, "R4 disabled miss");
    req(32'hFFFF_FFFC, "R9 passthrough");
    idle(2);

    // R2: program window
    wr(5'h0C, 32'h0100_0000);
    wr(5'h14, 32'h010F_FFFF);
    wr(5'h18, 32'h4000_0000);
    wr(5'h1C, 32'h0000_0002);
    wr(5'h04, 32'h0000_0000);
    wr(5'h08, 32'h8000_0000);
    for (int k = 0; k < 8; k++) rd(5'(k * 4), "R2 readback");
    rd(5'h02, "R2 unmapped offset");

    // R5 / R6: inclusive edges, back to back
    req(32'h0100_0000, "R5 base edge hit");
    req(32'h010F_FFFF, "R5 limit edge hit");
    req(32'h00FF_FFFF, "R5 below base miss");
    req(32'h0110_0000, "R5 above limit miss");
    req(32'h0108_1234, "R6 memory mid");
    wr(5'h18, 32'hFFFF_FF00);
    req(32'h0100_0200, "R6 low word wrap");
    wr(5'h18, 32'h4000_0000);

    // R8: other kinds
    wr(5'h04, 32'h1);
    req(32'h0100_4444, "R8 locked read");
    wr(5'h04, 32'h2);
    req(32'h0100_0008, "R8 io");

    // R7: configuration kinds with bus 3, dev 5, fn 2
    wr(5'h18, (32'd3 << 24) | (32'd5 << 19) | (32'd2 << 16));
    wr(5'h04, 32'h4);
    req(32'h0100_012F, "R7 type0 cfg");
    wr(5'h04, 32'h5);
    req(32'h0103_ABCD, "R7 type1 cfg");

    // R5: nonzero base high blocks hits
    wr(5'h10, 32'h1);
    req(32'h0100_0100, "R5 base high miss");
    wr(5'h10, 32'h0);
    req(32'h0100_0100, "R5 base high cleared");

    // R11: write and request in the same cycle
    wrReq(5'h08, 32'h0, 32'h0100_0040, "R11 old enable");
    req(32'h0100_0040, "R11 new enable");
    wr(5'h08, 32'h8000_0000);
    wrReq(5'h0C, 32'h0100_0100, 32'h0100_0080, "R11 old base");
    req(32'h0100_0080, "R11 new base");
    idle(2);

    // R3: hidden window
    wr(5'h00, 32'h1);
    rd(5'h00, "R3 selector readable");
    rd(5'h0C, "R3 hidden read");
    rd(5'h04, "R3 hidden kind");
    wr(5'h0C, 32'h0200_0000);
    wr(5'h00, 32'h0);
    rd(5'h0C, "R3 write ignored");
    req(32'h0100_0100, "R3 window unchanged");
    idle(3);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10: pending responses got %0d expected 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule